// File: doc/BRIEF.md
# Multiplexed-Bus Pseudo-Static RAM Front End

This block is the device side of a 16-bit pseudo-static RAM whose address and data share one set of bus lines. On a clock edge with the chip selected and the address-valid strobe low, it captures the address from the shared lines and the upper address pins. On the cycles that follow, the same lines carry data. Each access goes either to an internal word array, whose depth is a parameter standing in for the full 4M-word organisation, or to one of two configuration registers. One of these registers holds the power-down choice. The other holds the bus mode and the burst length.

In asynchronous mode an access is a single word: a write happens on every clock edge while write enable is low, and a read drives the latched word while output enable is low. In synchronous mode the operation type is fixed when the address is captured. The word pointer then advances on every clock edge of the data phase. Reads stop after a programmed number of words or run continuously. Writes always run continuously. Two byte enables gate each half of the word in both directions.

While chip enable is high the block ignores the bus. It reports either standby or deep power-down, depending on a bit in the refresh register. Entering deep power-down wipes the array, and only a new chip-enable low brings the block out of that state.

Top module: `psram_mux_front`

## Requirements
- R1: After reset, standby is 1, deep power-down is 0, no data byte is driven, the bus configuration register reads 0x0007 (asynchronous, continuous) and the refresh configuration register reads 0x0000.
- R2: A rising clock edge with ce_n and adv_n both low captures the address {addr_hi, dq_in}, the state of cre, and the state of we_n. The array uses only the low log2(ARRAY_DEPTH) address bits, so higher bits alias.
- R3: In asynchronous mode, each rising edge in the data phase (ce_n low, adv_n high, after a capture) with we_n low writes dq_in to the latched word. Only the byte lanes whose enable is low are written (ub_n for bits 15:8, lb_n for bits 7:0).
- R4: A read drives dq_out with the addressed word while ce_n and oe_n are low, adv_n is high and the access is a read. dq_oe[1] follows !ub_n and dq_oe[0] follows !lb_n. A lane that is not driven shows 0.
- R5: With ub_n and lb_n both high, nothing is driven and nothing is written, and standby stays 0 while ce_n is low.
- R6: When cre is high at capture, the access reaches a configuration register and leaves the array untouched. Address bit 19 = 0 selects the refresh register and = 1 selects the bus register. Bus register: bit 15 = synchronous mode and bits 2:0 = burst code. Refresh register: bit 4 = deep power-down enable. All other bits read 0.
- R7: In synchronous mode, a read with burst code 001/010/011/100 presents 4/8/16/32 consecutive words, one per clock edge, starting at the captured address. After the last word it stops driving.
- R8: In synchronous mode, a read with burst code 111 (or any other unlisted code) keeps advancing until ce_n goes high.
- R9: In synchronous mode, a write (we_n low at capture) stores dq_in on every data-phase edge and advances the address, whatever the burst code.
- R10: A rising edge with ce_n high and the deep power-down bit 0 sets standby to 1. A rising edge with ce_n low clears standby and deep power-down. Standby and deep power-down are never both 1.
- R11: A rising edge with ce_n high and the deep power-down bit 1 sets deep power-down and clears the array to zero. The state holds until an edge with ce_n low.
- R12: While ce_n is high nothing is driven and writes are ignored. The access is closed, so after ce_n returns low nothing is read or written until a new address capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte enable (bits 15:8), active low |
| lb_n | input | 1 | Lower byte enable (bits 7:0), active low |
| cre | input | 1 | Configuration-register access select, active high |
| addr_hi | input | ADDR_W-16 | Upper address bits |
| dq_in | input | 16 | Shared address/data lines, inbound |
| dq_out | output | 16 | Shared data lines, outbound |
| dq_oe | output | 2 | Per-byte drive enable (bit 1 = upper) |
| standby | output | 1 | Deselected, low-power standby |
| deep_pd | output | 1 | Deselected, deep power-down |

## Verification
The bench builds the block with its defaults: a 64-word array, a 22-bit address and the register select on bit 19. The small array makes the wipe on deep power-down cheap to observe. A 22-bit address puts bit 19 on the upper pins, so an array access with that bit set shows that the high bits alias and that only cre redirects a cycle. A 4-word burst and a 6-word continuous run fit inside the array, so the end of a fixed burst and the lack of an end on a continuous one can both be seen at the pins.

// File: rtl/psram_fe_pkg.sv
package psram_fe_pkg;

   localparam int BUS_W = 16;
   localparam int LANES = BUS_W / 8;

   typedef enum logic [2:0] {
      BURST_4    = 3'b001,
      BURST_8    = 3'b010,
      BURST_16   = 3'b011,
      BURST_32   = 3'b100,
      BURST_CONT = 3'b111
   } burst_code_e;

   localparam int          MODE_BIT    = 15;
   localparam int          DPD_BIT     = 4;
   localparam logic [15:0] BUS_CFG_MSK = 16'h8007;
   localparam logic [15:0] REF_CFG_MSK = 16'h0010;
   localparam logic [15:0] BUS_CFG_RST = 16'h0007;
   localparam logic [15:0] REF_CFG_RST = 16'h0000;

   // word count of a fixed burst; zero means the burst never ends by itself
   function automatic logic [5:0] burst_words(input logic [2:0] code);
      case (code)
         BURST_4:  return 6'd4;
         BURST_8:  return 6'd8;
         BURST_16: return 6'd16;
         BURST_32: return 6'd32;
         default:  return 6'd0;
      endcase
   endfunction

endpackage

// File: rtl/psram_cfg_regs.sv
module psram_cfg_regs
   import psram_fe_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             sel_bus,
   input  logic [LANES-1:0] lane_en,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             sync_mode,
   output logic [2:0]       burst_code,
   output logic             dpd_en
);

   logic [BUS_W-1:0] ref_q;
   logic [BUS_W-1:0] bus_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= REF_CFG_RST;
         bus_q <= BUS_CFG_RST;
      end else if (wr_en) begin
         for (int l = 0; l < LANES; l++) begin
            if (lane_en[l]) begin
               if (sel_bus)
                  bus_q[l*8 +: 8] <= wdata[l*8 +: 8] & BUS_CFG_MSK[l*8 +: 8];
               else
                  ref_q[l*8 +: 8] <= wdata[l*8 +: 8] & REF_CFG_MSK[l*8 +: 8];
            end
         end
      end
   end

   assign rdata      = sel_bus ? bus_q : ref_q;
   assign sync_mode  = bus_q[MODE_BIT];
   assign burst_code = bus_q[2:0];
   assign dpd_en     = ref_q[DPD_BIT];

endmodule

// File: rtl/psram_word_array.sv
module psram_word_array
   import psram_fe_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wipe,
   input  logic             wr_en,
   input  logic [LANES-1:0] lane_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata
);

   logic [BUS_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wipe) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en) begin
         for (int l = 0; l < LANES; l++)
            if (lane_en[l]) mem_q[idx][l*8 +: 8] <= wdata[l*8 +: 8];
      end
   end

   assign rdata = mem_q[idx];

endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl #(
   parameter int ADDR_W  = 22,
   parameter int IDX_W   = 6,
   parameter int SEL_POS = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              adv_n,
   input  logic              we_n,
   input  logic              cre,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              sync_mode,
   input  logic [5:0]        burst_len,
   output logic [IDX_W-1:0]  idx,
   output logic              cfg_hit,
   output logic              cfg_sel_bus,
   output logic              data_phase,
   output logic              wr_dir
);

   logic [IDX_W-1:0] idx_q;
   logic             cfg_q, sel_q, wr_q, open_q;
   logic [5:0]       beat_q;
   logic             step;

   assign data_phase = open_q && !ce_n && adv_n;
   assign step       = data_phase && sync_mode && !cfg_q;
   assign wr_dir     = sync_mode ? wr_q : !we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         cfg_q  <= 1'b0;
         sel_q  <= 1'b0;
         wr_q   <= 1'b0;
         open_q <= 1'b0;
         beat_q <= '0;
      end else if (!ce_n && !adv_n) begin
         idx_q  <= addr_in[IDX_W-1:0];
         sel_q  <= addr_in[SEL_POS];
         cfg_q  <= cre;
         wr_q   <= !we_n;
         open_q <= 1'b1;
         beat_q <= '0;
      end else if (ce_n) begin
         open_q <= 1'b0;
      end else if (step) begin
         idx_q  <= idx_q + 1'b1;
         beat_q <= beat_q + 1'b1;
         if (!wr_q && burst_len != 6'd0 && beat_q == burst_len - 6'd1)
            open_q <= 1'b0;
      end
   end

   assign idx         = idx_q;
   assign cfg_hit     = cfg_q;
   assign cfg_sel_bus = sel_q;

endmodule

// File: rtl/psram_mux_front.sv
module psram_mux_front
   import psram_fe_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int ARRAY_DEPTH = 64,
   parameter int CFG_SEL_BIT = 19,
   localparam int HI_W  = ADDR_W - BUS_W,
   localparam int IDX_W = $clog2(ARRAY_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             adv_n,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic             ub_n,
   input  logic             lb_n,
   input  logic             cre,
   input  logic [HI_W-1:0]  addr_hi,
   input  logic [BUS_W-1:0] dq_in,
   output logic [BUS_W-1:0] dq_out,
   output logic [LANES-1:0] dq_oe,
   output logic             standby,
   output logic             deep_pd
);

   if (ADDR_W <= BUS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the bus width");
   end
   if (CFG_SEL_BIT >= ADDR_W || CFG_SEL_BIT < IDX_W) begin : g_bad_sel
      $error("CFG_SEL_BIT must lie above the array index and inside the address");
   end
   if (ARRAY_DEPTH < 2 || (1 << IDX_W) != ARRAY_DEPTH || IDX_W > BUS_W) begin : g_bad_depth
      $error("ARRAY_DEPTH must be a power of two addressable from the bus");
   end

   logic [LANES-1:0] lane_en;
   logic [IDX_W-1:0] idx;
   logic             cfg_hit, cfg_sel_bus, data_phase, wr_dir;
   logic             sync_mode, dpd_en;
   logic [2:0]       burst_code;
   logic [BUS_W-1:0] arr_word, cfg_word, rd_word;
   logic             wr_cycle, rd_cycle, wipe;
   logic             standby_q, deep_pd_q;

   assign lane_en  = {~ub_n, ~lb_n};
   assign wr_cycle = data_phase && wr_dir;
   assign rd_cycle = data_phase && !wr_dir && !oe_n;
   assign wipe     = ce_n && dpd_en && !deep_pd_q;
   assign rd_word  = cfg_hit ? cfg_word : arr_word;

   psram_burst_ctrl #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .SEL_POS(CFG_SEL_BIT)
   ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .adv_n      (adv_n),
      .we_n       (we_n),
      .cre        (cre),
      .addr_in    ({addr_hi, dq_in}),
      .sync_mode  (sync_mode),
      .burst_len  (burst_words(burst_code)),
      .idx        (idx),
      .cfg_hit    (cfg_hit),
      .cfg_sel_bus(cfg_sel_bus),
      .data_phase (data_phase),
      .wr_dir     (wr_dir)
   );

   psram_cfg_regs i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_cycle && cfg_hit),
      .sel_bus   (cfg_sel_bus),
      .lane_en   (lane_en),
      .wdata     (dq_in),
      .rdata     (cfg_word),
      .sync_mode (sync_mode),
      .burst_code(burst_code),
      .dpd_en    (dpd_en)
   );

   psram_word_array #(.DEPTH(ARRAY_DEPTH)) i_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .wipe   (wipe),
      .wr_en  (wr_cycle && !cfg_hit),
      .lane_en(lane_en),
      .idx    (idx),
      .wdata  (dq_in),
      .rdata  (arr_word)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign dq_oe[l]          = rd_cycle && lane_en[l];
      assign dq_out[l*8 +: 8]  = (rd_cycle && lane_en[l]) ? rd_word[l*8 +: 8] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         standby_q <= 1'b1;
         deep_pd_q <= 1'b0;
      end else if (!ce_n) begin
         standby_q <= 1'b0;
         deep_pd_q <= 1'b0;
      end else if (!deep_pd_q) begin
         standby_q <= !dpd_en;
         deep_pd_q <= dpd_en;
      end
   end

   assign standby = standby_q;
   assign deep_pd = deep_pd_q;

endmodule

// File: rtl/psram_mux_front_chk.sv
module psram_mux_front_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ce_n,
   input logic       ub_n,
   input logic       lb_n,
   input logic [1:0] dq_oe,
   input logic       standby,
   input logic       deep_pd
);

   assert_upper_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe[1] |-> !ub_n);

   assert_lower_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe[0] |-> !lb_n);

   assert_no_drive_idle_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ub_n && lb_n) |-> dq_oe == 2'b00);

   assert_no_drive_deselected_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> dq_oe == 2'b00);

   assert_wake_on_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_n |=> (!standby && !deep_pd));

   assert_low_power_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (standby || deep_pd));

   assert_exclusive_states_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(standby && deep_pd));

   assert_dpd_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (deep_pd && ce_n) |=> deep_pd);

endmodule

bind psram_mux_front psram_mux_front_chk i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ce_n   (ce_n),
   .ub_n   (ub_n),
   .lb_n   (lb_n),
   .dq_oe  (dq_oe),
   .standby(standby),
   .deep_pd(deep_pd)
);

// File: tb/test_psram_mux_front.sv
module test_psram_mux_front;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic        ub_n = 1'b1, lb_n = 1'b1, cre = 1'b0;
   logic [5:0]  addr_hi = '0;
   logic [15:0] dq_in = '0;
   logic [15:0] dq_out;
   logic [1:0]  dq_oe;
   logic        standby, deep_pd;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   localparam logic [21:0] REF_ADDR = 22'h000000;
   localparam logic [21:0] BUS_ADDR = 22'h080000;

   typedef struct packed {
      logic [21:0] a;
      logic [15:0] d;
      logic [1:0]  ben;   // {ub_n, lb_n} during the write
      logic [15:0] exp;
   } vec_t;

   localparam vec_t VEC [7] = '{
      '{22'h000005, 16'hA1B2, 2'b00, 16'hA1B2},
      '{22'h000006, 16'hC3D4, 2'b01, 16'hC300},
      '{22'h000007, 16'hE5F6, 2'b10, 16'h00F6},
      '{22'h000008, 16'h1234, 2'b11, 16'h0000},
      '{22'h000005, 16'h9999, 2'b10, 16'hA199},
      '{22'h3F0009, 16'h7777, 2'b00, 16'h7777},
      '{22'h000000, 16'h5555, 2'b00, 16'h5555}
   };

   psram_mux_front i_psram_mux_front (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
      .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .cre(cre), .addr_hi(addr_hi),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .standby(standby),
      .deep_pd(deep_pd)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic capture(input logic cfg, input logic [21:0] a, input logic wr);
      @(negedge clk);
      ce_n = 1'b0; adv_n = 1'b0; oe_n = 1'b1; cre = cfg;
      we_n = !wr; ub_n = 1'b1; lb_n = 1'b1;
      addr_hi = a[21:16]; dq_in = a[15:0];
      @(posedge clk);
   endtask

   task automatic release_bus();
      @(negedge clk);
      ce_n = 1'b1; adv_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; cre = 1'b0;
      ub_n = 1'b1; lb_n = 1'b1;
      @(posedge clk);
   endtask

   task automatic put_word(input logic cfg, input logic [21:0] a,
                           input logic [15:0] d, input logic [1:0] ben);
      capture(cfg, a, 1'b1);
      @(negedge clk);
      adv_n = 1'b0 ^ 1'b1; we_n = 1'b0; {ub_n, lb_n} = ben; dq_in = d;
      @(posedge clk);
      release_bus();
   endtask

   task automatic get_word(input logic cfg, input logic [21:0] a, input logic [1:0] ben,
                           output logic [15:0] d, output logic [1:0] oe);
      capture(cfg, a, 1'b0);
      @(negedge clk);
      adv_n = 1'b1; oe_n = 1'b0; {ub_n, lb_n} = ben;
      #1;
      d = dq_out; oe = dq_oe;
      release_bus();
   endtask

   logic [15:0] rd;
   logic [1:0]  rdoe;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 standby", standby, 1);
      chk("R1 deep_pd", deep_pd, 0);
      chk("R1 dq_oe", dq_oe, 0);
      get_word(1'b1, BUS_ADDR, 2'b00, rd, rdoe);
      chk("R1 bus cfg reset", rd, 16'h0007);
      get_word(1'b1, REF_ADDR, 2'b00, rd, rdoe);
      chk("R1 ref cfg reset", rd, 16'h0000);

      // R3 R4 vector table: byte-masked async writes, full-width reads
      for (int i = 0; i < 7; i++) begin
         put_word(1'b0, VEC[i].a, VEC[i].d, VEC[i].ben);
         get_word(1'b0, VEC[i].a, 2'b00, rd, rdoe);
         chk($sformatf("R3 table row %0d data", i), rd, VEC[i].exp);
         chk($sformatf("R4 table row %0d oe", i), rdoe, 2'b11);
      end

      // R2 high address bits alias onto the same word
      get_word(1'b0, 22'h000009, 2'b00, rd, rdoe);
      chk("R2 alias of 0x3F0009", rd, 16'h7777);

      // R4 single lane read
      get_word(1'b0, 22'h000005, 2'b01, rd, rdoe);
      chk("R4 upper-only data", rd, 16'hA100);
      chk("R4 upper-only oe", rdoe, 2'b10);

      // R5 both lanes off: no drive, still active
      capture(1'b0, 22'h000005, 1'b0);
      @(negedge clk);
      adv_n = 1'b1; oe_n = 1'b0; ub_n = 1'b1; lb_n = 1'b1;
      @(posedge clk); @(negedge clk); #1;
      chk("R5 oe off", dq_oe, 2'b00);
      chk("R5 standby low", standby, 0);
      release_bus();
      put_word(1'b0, 22'h000005, 16'h0000, 2'b11);
      get_word(1'b0, 22'h000005, 2'b00, rd, rdoe);
      chk("R5 write with lanes off ignored", rd, 16'hA199);

      // R6 config masking and array isolation
      put_word(1'b1, BUS_ADDR, 16'h7FF3, 2'b00);
      get_word(1'b1, BUS_ADDR, 2'b00, rd, rdoe);
      chk("R6 bus cfg masked", rd, 16'h0003);
      put_word(1'b1, REF_ADDR, 16'hFFEF, 2'b00);
      get_word(1'b1, REF_ADDR, 2'b00, rd, rdoe);
      chk("R6 ref cfg masked", rd, 16'h0000);
      get_word(1'b0, 22'h000000, 2'b00, rd, rdoe);
      chk("R6 array untouched", rd, 16'h5555);

      // fill words 16..23 for bursts
      for (int i = 0; i < 8; i++) put_word(1'b0, 22'(16 + i), 16'(16'h0100 + i), 2'b00);

      // R7 synchronous read, 4-word burst
      put_word(1'b1, BUS_ADDR, 16'h8001, 2'b00);
      capture(1'b0, 22'd16, 1'b0);
      @(negedge clk);
      adv_n = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
      for (int k = 0; k < 5; k++) begin
         if (k > 0) begin @(posedge clk); @(negedge clk); end
         #1;
         if (k < 4) chk($sformatf("R7 beat %0d", k), dq_out, 16'h0100 + k);
         else       chk("R7 burst end oe", dq_oe, 2'b00);
      end
      release_bus();

      // R8 continuous read runs past 4 words
      put_word(1'b1, BUS_ADDR, 16'h8007, 2'b00);
      capture(1'b0, 22'd16, 1'b0);
      @(negedge clk);
      adv_n = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
      for (int k = 0; k < 6; k++) begin
         if (k > 0) begin @(posedge clk); @(negedge clk); end
         #1;
         chk($sformatf("R8 beat %0d", k), {dq_oe, dq_out}, {2'b11, 16'h0100 + 16'(k)});
      end
      release_bus();

      // R9 synchronous write continues past the 4-word code
      put_word(1'b1, BUS_ADDR, 16'h8001, 2'b00);
      capture(1'b0, 22'd32, 1'b1);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         adv_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0; dq_in = 16'h0200 + 16'(k);
         @(posedge clk);
      end
      release_bus();
      put_word(1'b1, BUS_ADDR, 16'h0007, 2'b00);
      for (int k = 0; k < 6; k++) begin
         get_word(1'b0, 22'(32 + k), 2'b00, rd, rdoe);
         chk($sformatf("R9 word %0d", k), rd, 16'h0200 + 16'(k));
      end

      // R12 deselect closes the access
      capture(1'b0, 22'd40, 1'b1);
      @(negedge clk);
      ce_n = 1'b1; adv_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
      dq_in = 16'hDEAD;
      #1 chk("R12 no drive when deselected", dq_oe, 2'b00);
      @(posedge clk);
      @(negedge clk) ce_n = 1'b0;
      @(posedge clk);
      release_bus();
      get_word(1'b0, 22'd40, 2'b00, rd, rdoe);
      chk("R12 writes ignored", rd, 16'h0000);

      // R10 standby
      @(negedge clk); #1;
      chk("R10 standby", {standby, deep_pd}, 2'b10);
      @(negedge clk) ce_n = 1'b0;
      @(negedge clk); #1;
      chk("R10 awake", {standby, deep_pd}, 2'b00);
      release_bus();

      // R11 deep power-down wipes array
      put_word(1'b1, REF_ADDR, 16'h0010, 2'b00);
      @(negedge clk); #1;
      chk("R11 enter", {standby, deep_pd}, 2'b01);
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R11 held", deep_pd, 1);
      get_word(1'b0, 22'h000005, 2'b00, rd, rdoe);
      chk("R11 contents lost", rd, 16'h0000);
      get_word(1'b1, REF_ADDR, 2'b00, rd, rdoe);
      chk("R11 register kept", rd, 16'h0010);
      put_word(1'b1, REF_ADDR, 16'h0000, 2'b00);
      @(negedge clk); #1;
      chk("R11 exit to standby", {standby, deep_pd}, 2'b10);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule